// File: doc/BRIEF.md
# Super-Page Striping Bus Sequencer

This block expands one super-page command into page-level commands across a grid of flash buses, each bus carrying several dies. A stripe mode selects which dies make up the super-page. Row striping uses die 0 of every bus. Column striping uses every die on bus 0. Grid striping uses every die on every bus. Each bus has its own lane sequencer. The lanes start together and run their die orders independently of one another.

For a program, a lane streams page data to its dies in ascending order with no idle beat between them. The program command for a die goes out with that die's last data beat. That die then programs while the next die receives its data. For a read, a lane first sends a read command to each of its dies, one per cycle. It then waits for each die's ready line and pulls that die's page out before moving on to the next die. When every lane has finished, the block raises a single-cycle done pulse. Each die has its own chip-enable output. A die model must drop its ready line by the cycle after it receives a command.

Top module: `superpage_stripe_seq`

## Requirements
- R1: After reset, busy, done, every command strobe, every transfer strobe and every chip-enable are low.
- R2: A start with mode 0 (row), 1 (column) or 2 (grid) is accepted when idle, and busy rises on the next cycle. The dies in the stripe are as follows: mode 0 is die 0 of every bus, mode 1 is all dies of bus 0, and mode 2 is all dies. Each die in the stripe receives exactly one command and BEATS transfer beats. Dies outside the stripe receive none.
- R3: For a program, each lane holds its transfer strobe high for one unbroken run of (dies in stripe)·BEATS cycles. Chip-enable selects the dies in ascending order, BEATS beats each. The command strobe is high exactly on each die's last beat.
- R4: For a read, the lane sends the read command to die i in cycle i after acceptance, and it sends all of its commands before its first transfer beat.
- R5: For a read, the data beats of a die occur only while that die's ready line is high, and dies are read out in ascending order.
- R6: Done is a single-cycle pulse, and busy falls on the following cycle. Let D be the number of dies per bus in the stripe, T the die busy time and L = BEATS. With equal die busy times of at least D cycles, a program raises done D·L+1+T cycles after acceptance, and a read raises it T+1+D·(L+1) cycles after acceptance.
- R7: In row and grid program operations, every bus drives its first transfer beat in the cycle right after acceptance, in parallel.
- R8: A start while busy is ignored and yields no second done. A start with mode 3 is ignored: busy stays low and no strobe is driven.
- R9: On each bus, at most one chip-enable is high, and a chip-enable is high exactly when a command or transfer strobe is high on that bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Super-page command request |
| op_prog | input | 1 | 1 = program, 0 = read |
| mode | input | 2 | Stripe mode: 0 row, 1 column, 2 grid, 3 invalid |
| die_rdy | input | NBUS·NDIE | Ready line per die, bus-major |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_cmd | output | NBUS | Command strobe per bus |
| bus_xfer | output | NBUS | Data transfer strobe per bus |
| bus_ce | output | NBUS·NDIE | Chip-enable per die, bus-major |

## Verification
Every stripe mode is run with both operations under a fixed die busy time, and then with random operations, modes and busy times. Row operations check that the lanes run in parallel. Column operations check that serial order and idle lanes are handled. Grid operations check that both act together. A read whose busy time is just long enough makes the lane stall on the ready line, which separates waiting on ready from skipping it. A second start during an operation, and a start with the invalid mode, show whether the block ignores those commands.

// File: rtl/stripe_pkg.sv
package stripe_pkg;
  typedef enum logic [1:0] {
    STRIPE_ROW  = 2'd0,
    STRIPE_COL  = 2'd1,
    STRIPE_GRID = 2'd2,
    STRIPE_NONE = 2'd3
  } stripe_e;

  typedef enum logic [2:0] {
    L_IDLE, L_STREAM, L_PWAIT, L_RCMD, L_RWAIT, L_RDATA, L_FIN
  } lane_e;

  function automatic logic stripe_ok(stripe_e m);
    return m != STRIPE_NONE;
  endfunction

  function automatic logic bus_in_stripe(stripe_e m, int b);
    return (m == STRIPE_COL) ? (b == 0) : 1'b1;
  endfunction

  function automatic int dies_in_stripe(stripe_e m, int ndie);
    return (m == STRIPE_ROW) ? 1 : ndie;
  endfunction
endpackage

// File: rtl/stripe_bus_lane.sv
module stripe_bus_lane
  import stripe_pkg::*;
#(
  parameter int NDIE  = 4,
  parameter int BEATS = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            go,
  input  logic                            clr,
  input  logic                            prog,
  input  logic                            used,
  input  logic [$clog2(NDIE+1)-1:0]       ndie,
  input  logic [NDIE-1:0]                 rdy,
  output logic [NDIE-1:0]                 ce,
  output logic                            cmd,
  output logic                            xfer,
  output logic                            fin
);
  localparam int CW = $clog2(NDIE+1);
  localparam int DW = (NDIE > 1) ? $clog2(NDIE) : 1;
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;

  lane_e          st_q;
  logic [DW-1:0]  die_q;
  logic [BW-1:0]  beat_q;
  logic [CW-1:0]  cnt_q;
  logic [NDIE-1:0] mask;
  logic           die_last, beat_last, all_rdy;

  assign die_last  = (CW'(die_q) == cnt_q - CW'(1));
  assign beat_last = (beat_q == BW'(BEATS - 1));

  always_comb begin
    for (int d = 0; d < NDIE; d++) mask[d] = (CW'(d) < cnt_q);
  end
  assign all_rdy = &(rdy | ~mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= L_IDLE;
      die_q  <= '0;
      beat_q <= '0;
      cnt_q  <= '0;
    end else begin
      case (st_q)
        L_IDLE: if (go) begin
          die_q  <= '0;
          beat_q <= '0;
          cnt_q  <= ndie;
          st_q   <= !used ? L_FIN : (prog ? L_STREAM : L_RCMD);
        end
        L_STREAM: begin
          if (beat_last) begin
            beat_q <= '0;
            if (die_last) st_q <= L_PWAIT;
            else          die_q <= die_q + DW'(1);
          end else beat_q <= beat_q + BW'(1);
        end
        L_PWAIT: if (all_rdy) st_q <= L_FIN;
        L_RCMD: begin
          if (die_last) begin
            die_q <= '0;
            st_q  <= L_RWAIT;
          end else die_q <= die_q + DW'(1);
        end
        L_RWAIT: if (rdy[die_q]) begin
          beat_q <= '0;
          st_q   <= L_RDATA;
        end
        L_RDATA: begin
          if (beat_last) begin
            beat_q <= '0;
            if (die_last) st_q <= L_FIN;
            else begin
              die_q <= die_q + DW'(1);
              st_q  <= L_RWAIT;
            end
          end else beat_q <= beat_q + BW'(1);
        end
        L_FIN: if (clr) st_q <= L_IDLE;
        default: st_q <= L_IDLE;
      endcase
    end
  end

  always_comb begin
    ce = '0;
    if (st_q == L_STREAM || st_q == L_RCMD || st_q == L_RDATA) ce[die_q] = 1'b1;
  end
  assign xfer = (st_q == L_STREAM) || (st_q == L_RDATA);
  assign cmd  = (st_q == L_RCMD) || (st_q == L_STREAM && beat_last);
  assign fin  = (st_q == L_FIN);
endmodule

// File: rtl/superpage_stripe_seq.sv
module superpage_stripe_seq
  import stripe_pkg::*;
#(
  parameter int NBUS  = 4,
  parameter int NDIE  = 4,
  parameter int BEATS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   op_prog,
  input  logic [1:0]             mode,
  input  logic [NBUS*NDIE-1:0]   die_rdy,
  output logic                   busy,
  output logic                   done,
  output logic [NBUS-1:0]        bus_cmd,
  output logic [NBUS-1:0]        bus_xfer,
  output logic [NBUS*NDIE-1:0]   bus_ce
);
  localparam int CW = $clog2(NDIE+1);

  stripe_e          mode_e;
  logic             busy_q, accept, all_fin;
  logic [NBUS-1:0]  lane_fin;
  logic [CW-1:0]    ndie_sel;

  assign mode_e   = stripe_e'(mode);
  assign accept   = start && !busy_q && stripe_ok(mode_e);
  assign ndie_sel = CW'(dies_in_stripe(mode_e, NDIE));
  assign all_fin  = &lane_fin;
  assign done     = busy_q && all_fin;
  assign busy     = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      busy_q <= 1'b0;
    else if (accept) busy_q <= 1'b1;
    else if (done)   busy_q <= 1'b0;
  end

  for (genvar b = 0; b < NBUS; b++) begin : g_lane
    stripe_bus_lane #(.NDIE(NDIE), .BEATS(BEATS)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (accept),
      .clr  (done),
      .prog (op_prog),
      .used (bus_in_stripe(mode_e, b)),
      .ndie (ndie_sel),
      .rdy  (die_rdy[b*NDIE +: NDIE]),
      .ce   (bus_ce[b*NDIE +: NDIE]),
      .cmd  (bus_cmd[b]),
      .xfer (bus_xfer[b]),
      .fin  (lane_fin[b])
    );
  end
endmodule

// File: rtl/superpage_stripe_chk.sv
module superpage_stripe_chk #(
  parameter int NBUS = 4,
  parameter int NDIE = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 op_prog,
  input logic [1:0]           mode,
  input logic                 accept,
  input logic [NBUS*NDIE-1:0] die_rdy,
  input logic                 busy,
  input logic                 done,
  input logic [NBUS-1:0]      bus_cmd,
  input logic [NBUS-1:0]      bus_xfer,
  input logic [NBUS*NDIE-1:0] bus_ce
);
  logic op_ck;
  always_ff @(posedge clk) begin
    if (!rst_n)      op_ck <= 1'b0;
    else if (accept) op_ck <= op_prog;
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_cmd == '0 && bus_xfer == '0));
  p_bad_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 2'd3) |=> !busy);

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    p_ce_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bus_ce[b*NDIE +: NDIE]));
    p_strobe_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_xfer[b] || bus_cmd[b]) |-> (|bus_ce[b*NDIE +: NDIE]));
    for (genvar d = 0; d < NDIE; d++) begin : g_die
      p_read_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_xfer[b] && !op_ck && bus_ce[b*NDIE+d]) |-> die_rdy[b*NDIE+d]);
    end
  end
endmodule

bind superpage_stripe_seq superpage_stripe_chk #(.NBUS(NBUS), .NDIE(NDIE)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_prog(op_prog), .mode(mode),
  .accept(accept), .die_rdy(die_rdy), .busy(busy), .done(done),
  .bus_cmd(bus_cmd), .bus_xfer(bus_xfer), .bus_ce(bus_ce)
);

// File: tb/tb_superpage_stripe_seq.sv
module tb_superpage_stripe_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int ND = 4;
  localparam int L  = 8;
  localparam int NG = NB*ND;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, op_prog = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [NG-1:0] die_rdy;
  logic busy, done;
  logic [NB-1:0] bus_cmd, bus_xfer;
  logic [NG-1:0] bus_ce;

  int n_run = 0, n_fail = 0;
  int lat = 10;
  int cnt [NG];

  always #(CLK_PERIOD/2) clk = ~clk;

  superpage_stripe_seq #(.NBUS(NB), .NDIE(ND), .BEATS(L)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_prog(op_prog), .mode(mode),
    .die_rdy(die_rdy), .busy(busy), .done(done), .bus_cmd(bus_cmd),
    .bus_xfer(bus_xfer), .bus_ce(bus_ce));

  // die model: ready drops after a command, returns after lat cycles
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) begin die_rdy[g] <= 1'b1; cnt[g] <= 0; end
    end else begin
      for (int g = 0; g < NG; g++) begin
        if (bus_cmd[g/ND] && bus_ce[g]) begin
          die_rdy[g] <= 1'b0; cnt[g] <= lat;
        end else if (cnt[g] > 0) begin
          cnt[g] <= cnt[g] - 1;
          if (cnt[g] == 1) die_rdy[g] <= 1'b1;
        end
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit in_stripe(int m, int b, int i);
    return (m == 0) ? (i == 0) : (m == 1) ? (b == 0) : 1'b1;
  endfunction
  function automatic int dies_of(int m);
    return (m == 0) ? 1 : ND;
  endfunction
  function automatic int exp_lat(bit p, int d, int t);
    return p ? d*L + 1 + t : t + 1 + d*(L+1);
  endfunction

  task automatic run_op(bit p, int m, int t, int restart_at);
    int beats [NG];
    int cmds [NG];
    int bus_beats [NB];
    int bus_cmds [NB];
    bit began [NB];
    bit ended [NB];
    int e_order = 0, e_ce = 0, e_rd = 0, e_gap = 0, e_par = 0, e_cmd = 0, e_rcmd = 0;
    int k = 0, d = dies_of(m), n_done = 0, done_k = -1;
    for (int g = 0; g < NG; g++) begin beats[g] = 0; cmds[g] = 0; end
    for (int b = 0; b < NB; b++) begin bus_beats[b] = 0; bus_cmds[b] = 0; began[b] = 0; ended[b] = 0; end
    lat = t;
    @(negedge clk);
    op_prog = p; mode = 2'(m); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (k < 1000) begin
      for (int b = 0; b < NB; b++) begin
        int ones = 0, idx = 0;
        for (int i = 0; i < ND; i++) if (bus_ce[b*ND+i]) begin ones++; idx = i; end
        if (ones != ((bus_xfer[b] || bus_cmd[b]) ? 1 : 0)) e_ce++;
        if (p && k == 0 && in_stripe(m, b, 0) && !bus_xfer[b]) e_par++;
        if (bus_xfer[b]) begin
          if (ended[b] && p) e_gap++;
          began[b] = 1;
          if (idx != bus_beats[b] / L) e_order++;
          if (!p && !die_rdy[b*ND+idx]) e_rd++;
          if (!p && bus_cmds[b] < d) e_rcmd++;
          beats[b*ND+idx]++; bus_beats[b]++;
        end else if (began[b]) ended[b] = 1;
        if (bus_cmd[b]) begin
          cmds[b*ND+idx]++; bus_cmds[b]++;
          if (!p && idx != k) e_rcmd++;
        end
        if (p && ((bus_cmd[b] && ones == 1) != (bus_xfer[b] && ones == 1 && beats[b*ND+idx] == L))) e_cmd++;
      end
      if (done) begin n_done++; if (done_k < 0) done_k = k; end
      if (done_k >= 0 && k >= done_k + 3) break;
      start = (k + 1 == restart_at);
      if (k + 1 == restart_at) begin op_prog = ~p; mode = 2'(m == 2 ? 0 : 2); end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    for (int g = 0; g < NG; g++) begin
      bit a = in_stripe(m, g/ND, g%ND);
      chk(beats[g] == (a ? L : 0), "R2 beats per die", beats[g], a ? L : 0);
      chk(cmds[g] == (a ? 1 : 0), "R2 commands per die", cmds[g], a ? 1 : 0);
    end
    chk(e_ce == 0, "R9 chip-enable vs strobe", e_ce, 0);
    chk(e_order == 0, p ? "R3 ascending die order" : "R5 ascending die order", e_order, 0);
    if (p) begin
      chk(e_gap == 0, "R3 unbroken data stream", e_gap, 0);
      chk(e_cmd == 0, "R3 command on last beat", e_cmd, 0);
      if (m != 1) chk(e_par == 0, "R7 buses start in parallel", e_par, 0);
    end else begin
      chk(e_rcmd == 0, "R4 read command timing", e_rcmd, 0);
      chk(e_rd == 0, "R5 data only while ready", e_rd, 0);
    end
    chk(done_k == exp_lat(p, d, t), "R6 done latency", done_k, exp_lat(p, d, t));
    chk(n_done == 1, restart_at > 0 ? "R8 start while busy ignored" : "R6 single done", n_done, 1);
    chk(busy == 1'b0, "R6 busy cleared", busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 reset busy/done", {busy, done}, 0);
    chk(bus_cmd == 0 && bus_xfer == 0 && bus_ce == 0, "R1 reset strobes", int'(bus_ce), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed: every mode and operation
    for (int m = 0; m < 3; m++) begin
      run_op(1'b1, m, 10, 0);
      run_op(1'b0, m, 10, 0);
    end
    // reads whose busy time is just long enough (lane stalls on ready)
    run_op(1'b0, 1, 4, 0);
    run_op(1'b0, 2, 4, 0);
    // second start while busy
    run_op(1'b1, 2, 12, 3);
    run_op(1'b0, 0, 12, 5);
    // invalid mode ignored
    begin
      int seen = 0;
      @(negedge clk);
      mode = 2'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 6; i++) begin
        if (busy || bus_cmd != 0 || bus_xfer != 0 || bus_ce != 0) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R8 mode 3 ignored", seen, 0);
    end
    // constrained random
    for (int i = 0; i < 24; i++) begin
      int m = int'($urandom % 3);
      run_op(1'($urandom % 2), m, 4 + int'($urandom % 37), 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule